// File: doc/BRIEF.md
# Smart Card Waiting-Time Watchdog

This block watches the bidirectional data line of a contact smart card interface and flags a card that has gone quiet for too long. It counts card clock cycles, which reach it as a one-cycle enable pulse in the system clock domain. It groups them into coarse ticks of twelve elementary time units (ETUs) each. It compares the number of ticks that have elapsed against a limit derived from the programmed waiting time.

Each falling edge on the data line marks the start of a character and restarts the measurement. The block raises a warning pulse when half of the allowed ticks have gone by. It raises an expiry pulse when all of them have gone by. After expiry the counter stops and waits, and the next falling edge starts a new measurement. Software-side control is limited to a start strobe, a stop strobe and two configuration values: the waiting time in ETUs and the number of card clocks per ETU. Typical values are 9600 and 372.

Top module: `sc_wt_watchdog`

## Requirements
- R1: After reset both outputs are low. The block stays idle and raises no pulse, however long it runs, until an enable strobe arrives.
- R2: One tick lasts `etu_clks_i` × 12 card clocks. A card clock is counted only on system clock cycles where `cclk_en_i` is high.
- R3: The tick limit is `wait_etu_i` / 12, truncated. `expired_o` pulses on the tick where the tick count reaches the limit. The counter then stops, and no further pulse appears without a new start.
- R4: `half_o` pulses once per measurement, on the tick where the tick count equals the limit / 2, truncated. It is suppressed when that value is zero. With a limit of 0 or 1, `expired_o` pulses at the end of the first tick.
- R5: A falling edge on `io_i` passes through a two-flop synchronizer and takes effect on the third clock edge after it. It clears the tick count and restarts the cycle count from zero, both while counting and after expiry. A rising edge has no effect.
- R6: An enable strobe clears the tick count and cycle count and starts counting at once, including in the middle of a measurement.
- R7: A disable strobe stops counting and clears the tick count. Falling edges on `io_i` are ignored while disabled. A disable strobe wins over an enable strobe in the same cycle.
- R8: The configuration inputs are registered once. New values change both the tick period and the tick limit of the next measurement.
- R9: Each output pulse lasts exactly one system clock cycle, and the two outputs are never high together.
- R10: When a falling edge takes effect on the same clock edge that ends a tick, the restart wins. That tick is discarded, and neither pulse it would have caused appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cclk_en_i | input | 1 | One pulse per card clock cycle |
| io_i | input | 1 | Card data line, asynchronous |
| enable_i | input | 1 | Start strobe |
| disable_i | input | 1 | Stop strobe |
| wait_etu_i | input | WAIT_W | Waiting time in ETUs |
| etu_clks_i | input | ETU_W | Card clocks per ETU |
| half_o | output | 1 | Half of the waiting time elapsed |
| expired_o | output | 1 | Full waiting time elapsed |

## Verification
The end of a tick and a restarting falling edge can land on the same clock edge. The bench provokes this by dropping the data line exactly three cycles before the second tick ends, which is the tick that would raise the half-time warning. It judges the result by requiring that no warning appear at that moment, and that both pulses then arrive a full half and a full waiting time after the restart. A mid-run enable strobe, and a simultaneous enable and disable strobe, are judged the same way through the timing of the pulses.

// File: rtl/sc_wt_pkg.sv
package sc_wt_pkg;
  localparam int unsigned ETUS_PER_TICK = 12;

  typedef enum logic [1:0] {
    WT_IDLE = 2'd0,
    WT_RUN  = 2'd1,
    WT_DONE = 2'd2
  } wt_state_e;
endpackage

// File: rtl/sc_wt_io_sync.sv
module sc_wt_io_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b1;
          else         sync_q[i] <= io_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b1;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sc_wt_cfg.sv
module sc_wt_cfg
  import sc_wt_pkg::*;
#(
  parameter int unsigned WAIT_W   = 16,
  parameter int unsigned ETU_W    = 16,
  parameter int unsigned PERIOD_W = ETU_W + 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WAIT_W-1:0]   wait_etu_i,
  input  logic [ETU_W-1:0]    etu_clks_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic [WAIT_W-1:0]   limit_o,
  output logic [WAIT_W-1:0]   half_o
);
  localparam logic [PERIOD_W-1:0] MUL_K = PERIOD_W'(ETUS_PER_TICK);
  localparam logic [WAIT_W-1:0]   DIV_K = WAIT_W'(ETUS_PER_TICK);

  logic [WAIT_W-1:0] limit_d;
  assign limit_d = wait_etu_i / DIV_K;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      limit_o  <= '0;
      half_o   <= '0;
    end else begin
      period_o <= PERIOD_W'(etu_clks_i) * MUL_K;
      limit_o  <= limit_d;
      half_o   <= limit_d >> 1;
    end
  end
endmodule

// File: rtl/sc_wt_period.sv
module sc_wt_period #(
  parameter int unsigned PERIOD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                clear_i,
  input  logic                cclk_en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cyc_q;
  logic                at_end;

  // period of zero degenerates to one tick per card clock
  assign at_end = ({1'b0, cyc_q} + 1'b1) >= {1'b0, period_i};
  assign tick_o = run_i & cclk_en_i & at_end & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (clear_i || !run_i) begin
      cyc_q <= '0;
    end else if (cclk_en_i) begin
      cyc_q <= at_end ? '0 : cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_wt_watchdog.sv
module sc_wt_watchdog
  import sc_wt_pkg::*;
#(
  parameter int unsigned WAIT_W  = 16,
  parameter int unsigned ETU_W   = 16,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cclk_en_i,
  input  logic              io_i,
  input  logic              enable_i,
  input  logic              disable_i,
  input  logic [WAIT_W-1:0] wait_etu_i,
  input  logic [ETU_W-1:0]  etu_clks_i,
  output logic              half_o,
  output logic              expired_o
);
  localparam int unsigned PERIOD_W = ETU_W + 8;

  wt_state_e           state_q;
  logic [WAIT_W-1:0]   ticks_q;
  logic [WAIT_W:0]     ticks_nx;
  logic [PERIOD_W-1:0] period;
  logic [WAIT_W-1:0]   limit;
  logic [WAIT_W-1:0]   half_pt;
  logic                io_fall;
  logic                restart;
  logic                clear;
  logic                tick;

  sc_wt_io_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .io_i   (io_i),
    .fall_o (io_fall)
  );

  sc_wt_cfg #(.WAIT_W(WAIT_W), .ETU_W(ETU_W), .PERIOD_W(PERIOD_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_etu_i (wait_etu_i),
    .etu_clks_i (etu_clks_i),
    .period_o   (period),
    .limit_o    (limit),
    .half_o     (half_pt)
  );

  assign restart = io_fall && (state_q != WT_IDLE);
  assign clear   = disable_i | enable_i | restart;

  sc_wt_period #(.PERIOD_W(PERIOD_W)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == WT_RUN),
    .clear_i   (clear),
    .cclk_en_i (cclk_en_i),
    .period_i  (period),
    .tick_o    (tick)
  );

  assign ticks_nx = {1'b0, ticks_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= WT_IDLE;
      ticks_q   <= '0;
      half_o    <= 1'b0;
      expired_o <= 1'b0;
    end else begin
      half_o    <= 1'b0;
      expired_o <= 1'b0;
      if (disable_i) begin
        state_q <= WT_IDLE;
        ticks_q <= '0;
      end else if (enable_i || restart) begin
        state_q <= WT_RUN;
        ticks_q <= '0;
      end else if (tick) begin
        ticks_q <= ticks_nx[WAIT_W-1:0];
        if (ticks_nx >= {1'b0, limit}) begin
          state_q   <= WT_DONE;
          expired_o <= 1'b1;
        end else if (ticks_nx == {1'b0, half_pt} && half_pt != '0) begin
          half_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_wt_watchdog_chk.sv
module sc_wt_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic disable_i,
  input logic half_o,
  input logic expired_o
);
  p_half_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |=> !half_o);

  p_exp_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> !expired_o);

  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_o && expired_o));

  p_stop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !half_o && !expired_o);

  p_start_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> !half_o && !expired_o);
endmodule

bind sc_wt_watchdog sc_wt_watchdog_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .disable_i (disable_i),
  .half_o    (half_o),
  .expired_o (expired_o)
);

// File: tb/sc_wt_watchdog_bench.sv
module sc_wt_watchdog_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cclk_en_i = 1'b1;
  logic        io_i = 1'b1;
  logic        enable_i = 1'b0;
  logic        disable_i = 1'b0;
  logic [15:0] wait_etu_i = 16'd48;
  logic [15:0] etu_clks_i = 16'd2;
  logic        half_o, expired_o;

  int checks = 0, errors = 0;
  int h_cnt, h_at, x_cnt, x_at;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sc_wt_watchdog u_sc_wt_watchdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .cclk_en_i(cclk_en_i), .io_i(io_i),
    .enable_i(enable_i), .disable_i(disable_i), .wait_etu_i(wait_etu_i),
    .etu_clks_i(etu_clks_i), .half_o(half_o), .expired_o(expired_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, input int e);
    @(negedge clk_i);
    wait_etu_i = 16'(w);
    etu_clks_i = 16'(e);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic kick();
    @(negedge clk_i) enable_i = 1'b1;
    @(negedge clk_i) enable_i = 1'b0;
  endtask

  // c counts edges since the start strobe; inputs set at c are sampled at edge c+1
  task automatic observe(input int span, input int io_at, input int dis_at,
                         input int en_at, input bit gate);
    h_cnt = 0; h_at = -1; x_cnt = 0; x_at = -1;
    for (int c = 0; c < span; c++) begin
      if (half_o)    begin h_cnt++; h_at = c; end
      if (expired_o) begin x_cnt++; x_at = c; end
      if (c == io_at) io_i = 1'b0;
      if (c == io_at + 10) io_i = 1'b1;
      disable_i = (c == dis_at);
      enable_i  = (c == en_at);
      if (gate) cclk_en_i = (c % 2 == 0);
      @(negedge clk_i);
    end
    cclk_en_i = 1'b1;
    disable_i = 1'b0;
    enable_i  = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "half after reset", int'(half_o), 0);
    check("R1", "expired after reset", int'(expired_o), 0);
    observe(300, -1, -1, -1, 0);
    check("R1", "half pulses while idle", h_cnt, 0);
    check("R1", "expired pulses while idle", x_cnt, 0);
  endtask

  task automatic t_basic();
    set_cfg(48, 2);
    kick();
    observe(400, -1, -1, -1, 0);
    check("R2", "half cycle", h_at, 48);
    check("R4", "half count", h_cnt, 1);
    check("R3", "expiry cycle", x_at, 96);
    check("R3", "expiry count after stop", x_cnt, 1);
    check("R9", "pulse width samples", h_cnt + x_cnt, 2);
  endtask

  task automatic t_restart();
    kick();
    observe(400, 60, -1, -1, 0);
    check("R5", "half count with restart", h_cnt, 2);
    check("R5", "half after restart", h_at, 111);
    check("R5", "expiry after restart", x_at, 159);
    check("R5", "expiry count", x_cnt, 1);
  endtask

  task automatic t_rearm();
    observe(300, 0, -1, -1, 0);
    check("R5", "rearm half", h_at, 51);
    check("R5", "rearm expiry", x_at, 99);
  endtask

  task automatic t_enable_mid();
    kick();
    observe(400, -1, -1, 60, 0);
    check("R6", "half count with re-enable", h_cnt, 2);
    check("R6", "half after re-enable", h_at, 109);
    check("R6", "expiry after re-enable", x_at, 157);
  endtask

  task automatic t_disable();
    kick();
    observe(400, 100, 30, -1, 0);
    check("R7", "half after disable", h_cnt, 0);
    check("R7", "expiry after disable", x_cnt, 0);
    @(negedge clk_i) begin enable_i = 1'b1; disable_i = 1'b1; end
    @(negedge clk_i) begin enable_i = 1'b0; disable_i = 1'b0; end
    observe(300, -1, -1, -1, 0);
    check("R7", "disable beats enable", h_cnt + x_cnt, 0);
  endtask

  task automatic t_gate();
    kick();
    observe(500, -1, -1, -1, 1);
    check("R2", "gated half", h_at, 95);
    check("R2", "gated expiry", x_at, 191);
  endtask

  task automatic t_small_limits();
    set_cfg(5, 2);
    kick();
    observe(200, -1, -1, -1, 0);
    check("R4", "limit 0 expiry", x_at, 24);
    check("R4", "limit 0 no half", h_cnt, 0);
    set_cfg(12, 2);
    kick();
    observe(200, -1, -1, -1, 0);
    check("R4", "limit 1 expiry", x_at, 24);
    check("R4", "limit 1 no half", h_cnt, 0);
  endtask

  task automatic t_odd_and_cfg();
    set_cfg(60, 2);
    kick();
    observe(300, -1, -1, -1, 0);
    check("R3", "limit 5 half", h_at, 48);
    check("R3", "limit 5 expiry", x_at, 120);
    set_cfg(24, 1);
    kick();
    observe(200, -1, -1, -1, 0);
    check("R8", "new config half", h_at, 12);
    check("R8", "new config expiry", x_at, 24);
  endtask

  task automatic t_collide();
    set_cfg(48, 2);
    kick();
    observe(400, 45, -1, -1, 0);
    check("R10", "half count on collision", h_cnt, 1);
    check("R10", "half after collision", h_at, 96);
    check("R10", "expiry after collision", x_at, 144);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_restart();
    t_rearm();
    t_enable_mid();
    t_disable();
    t_gate();
    t_small_limits();
    t_odd_and_cfg();
    t_collide();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule